// File: doc/BRIEF.md
# Pipelined Modular Multiplier (mod 2^16+1)

This block is a long-latency arithmetic unit for a cipher datapath. Each cycle it may take two 32-bit register operands and a valid strobe. It returns one 32-bit result with a matching valid exactly three cycles later. It accepts a new operation on every cycle, so a dense stream of operations keeps the pipeline full with no bubbles.

A per-operation mode bit selects the function. In the modular mode the block multiplies the low 16 bits of each operand modulo the prime 65537, the arithmetic that 16-bit block-cipher rounds rely on. A zero operand stands for 2^16, and a true result of 2^16 is returned as zero. In the plain mode it returns the low 32 bits of the full 32x32 product. The reduction folds the 32-bit product as its low half minus its high half, with a correction of one when that subtraction borrows. Because the slot counts as a long operation, no other operation is paired with it.

Top module: `modmul_unit`

## Requirements
- R1: While reset is held and until the first operation reaches the output, outValid is 0 and outResult is 0.
- R2: An operation sampled with inValid=1 at a rising edge raises outValid for exactly one cycle, after the third rising edge counted from and including the sampling edge. A cycle with inValid=0 produces no output cycle.
- R3: Operations issued on consecutive cycles each produce a result on consecutive cycles, in issue order, with no lost or repeated result.
- R4: With inMode=0 (modular), outResult[15:0] is (A*B) mod 65537 and outResult[31:16] is 0. Here A and B are inA[15:0] and inB[15:0], and inA[31:16] and inB[31:16] are ignored.
- R5: In modular mode, a true residue of 65536 is output as 0.
- R6: In modular mode, an operand whose low 16 bits are 0 stands for 65536. For example, A=0 and B=2 gives 65535, and A=5 and B=0 gives 65532.
- R7: In modular mode, when both operands are 0 the result is 1.
- R8: With inMode=1 (plain), outResult is the low 32 bits of inA*inB.
- R9: When outValid is 0, outResult keeps its previous value. Inputs presented with inValid=0 change neither output.
- R10: The mode is taken per operation, so modular and plain operations may be interleaved on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operation strobe |
| inMode | input | 1 | 0 = modular 65537, 1 = plain low product |
| inA | input | 32 | First operand |
| inB | input | 32 | Second operand |
| outValid | output | 1 | Result strobe, three cycles after the operation |
| outResult | output | 32 | Result |

## Verification
A stage valid bit that is lost or stuck shows at the ports within three cycles. It appears as a missing or extra outValid pulse, or as a result whose issue-to-output distance differs from three. A mode bit that drifts from its operand shows up on the next interleaved stream, because a plain product is then reduced or a residue is returned raw. Faults in the zero mapping and in the borrow correction stay hidden under ordinary operands. They appear only for a zero operand, for a residue of 65536, or for products whose high half exceeds their low half, so the bench aims operations at exactly those cases.

// File: rtl/modmul_pkg.sv
package modmul_pkg;
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;

  // Strobes from the control to the datapath, one set per cycle
  typedef struct packed {
    logic load1;   // capture conditioned operands
    logic mod1;    // operation entering stage 1 is modular
    logic load2;   // capture product
    logic load3;   // capture final result
    logic mod3;    // operation leaving stage 2 is modular
  } mmCtrl_t;
endpackage

// File: rtl/modmul_ctrl.sv
module modmul_ctrl
  import modmul_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inMode,
  output mmCtrl_t ctrl,
  output logic    outValid
);
  logic vld1, vld2, vld3;
  logic mode1, mode2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld1  <= 1'b0;
      vld2  <= 1'b0;
      vld3  <= 1'b0;
      mode1 <= 1'b0;
      mode2 <= 1'b0;
    end else begin
      vld1 <= inValid;
      vld2 <= vld1;
      vld3 <= vld2;
      if (inValid) mode1 <= inMode;
      if (vld1)    mode2 <= mode1;
    end
  end

  always_comb begin
    ctrl.load1 = inValid;
    ctrl.mod1  = !inMode;
    ctrl.load2 = vld1;
    ctrl.load3 = vld2;
    ctrl.mod3  = !mode2;
  end

  assign outValid = vld3;

  // R3: a stage that holds an operation always hands it on next cycle
  assert_stage_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    vld1 |=> vld2);
endmodule

// File: rtl/modmul_dp.sv
module modmul_dp
  import modmul_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mmCtrl_t           ctrl,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  output logic [DATA_W-1:0] outResult
);
  localparam logic [HALF_W-1:0] ONE_H = {{(HALF_W-1){1'b0}}, 1'b1};

  // stage 1: conditioned operands
  logic [DATA_W-1:0] opA, opB;
  logic              aZero1, bZero1;
  // stage 2: product and side data
  logic [DATA_W-1:0] prod;
  logic [HALF_W-1:0] aLow2, bLow2;
  logic              aZero2, bZero2;
  // stage 3 combinational reduction
  logic [HALF_W-1:0] loHalf, hiHalf;
  logic [HALF_W:0]   diff;
  logic              borrow;
  logic [HALF_W-1:0] folded, modResult;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opA    <= '0;
      opB    <= '0;
      aZero1 <= 1'b0;
      bZero1 <= 1'b0;
    end else if (ctrl.load1) begin
      opA    <= ctrl.mod1 ? {{HALF_W{1'b0}}, inA[HALF_W-1:0]} : inA;
      opB    <= ctrl.mod1 ? {{HALF_W{1'b0}}, inB[HALF_W-1:0]} : inB;
      aZero1 <= ctrl.mod1 && (inA[HALF_W-1:0] == '0);
      bZero1 <= ctrl.mod1 && (inB[HALF_W-1:0] == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prod   <= '0;
      aLow2  <= '0;
      bLow2  <= '0;
      aZero2 <= 1'b0;
      bZero2 <= 1'b0;
    end else if (ctrl.load2) begin
      prod   <= opA * opB;
      aLow2  <= opA[HALF_W-1:0];
      bLow2  <= opB[HALF_W-1:0];
      aZero2 <= aZero1;
      bZero2 <= bZero1;
    end
  end

  always_comb begin
    loHalf = prod[HALF_W-1:0];
    hiHalf = prod[DATA_W-1:HALF_W];
    diff   = {1'b0, loHalf} - {1'b0, hiHalf};
    borrow = diff[HALF_W];
    folded = diff[HALF_W-1:0] + {{(HALF_W-1){1'b0}}, borrow};
    if (aZero2 && bZero2)  modResult = ONE_H;
    else if (aZero2)       modResult = ONE_H - bLow2;
    else if (bZero2)       modResult = ONE_H - aLow2;
    else                   modResult = folded;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            outResult <= '0;
    else if (ctrl.load3)  outResult <= ctrl.mod3 ? {{HALF_W{1'b0}}, modResult} : prod;
  end

  // R4: a product of two nonzero residues of a prime is never zero before mapping
  assert_nonzero_residue_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load3 && ctrl.mod3 && !aZero2 && !bZero2 && !(loHalf == ONE_H && hiHalf == '0 && 1'b0)) |->
      (diff != '0));
  // R4: modular results carry nothing in the upper half
  assert_upper_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load3 && ctrl.mod3) |=> (outResult[DATA_W-1:HALF_W] == '0));
  // R9: the result register moves only when an operation completes
  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load3 |=> $stable(outResult));
endmodule

// File: rtl/modmul_unit.sv
module modmul_unit
  import modmul_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inMode,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  output logic              outValid,
  output logic [DATA_W-1:0] outResult
);
  mmCtrl_t ctrl;

  modmul_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inMode   (inMode),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  modmul_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .inA       (inA),
    .inB       (inB),
    .outResult (outResult)
  );

  // R2: every accepted operation yields a result three cycles on
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##3 outValid);
  // R2: an idle input cycle yields no result
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##3 !outValid);
endmodule

// File: tb/modmul_unit_tb.sv
module modmul_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inMode = 1'b0;
  logic [31:0] inA = '0;
  logic [31:0] inB = '0;
  logic        outValid;
  logic [31:0] outResult;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] expVal [64];
  int          expCyc [64];
  string       expTag [64];
  int wrIdx = 0;
  int rdIdx = 0;

  modmul_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMode(inMode),
    .inA(inA), .inB(inB), .outValid(outValid), .outResult(outResult)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] refMod(logic [31:0] a, logic [31:0] b);
    longint am, bm, r;
    am = (a[15:0] == 16'h0) ? 65536 : longint'(a[15:0]);
    bm = (b[15:0] == 16'h0) ? 65536 : longint'(b[15:0]);
    r  = (am * bm) % 65537;
    if (r == 65536) r = 0;
    return 32'(r);
  endfunction

  function automatic logic [31:0] refPlain(logic [31:0] a, logic [31:0] b);
    longint p;
    p = longint'(a) * longint'(b);
    return p[31:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // result monitor: compares value and issue-to-output distance
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (rdIdx == wrIdx) begin
        check("R2 unexpected outValid", 32'd1, 32'd0);
      end else begin
        check(expTag[rdIdx % 64], outResult, expVal[rdIdx % 64]);
        check({expTag[rdIdx % 64], " R2 latency"}, 32'(cyc - expCyc[rdIdx % 64]), 32'd3);
        rdIdx++;
      end
    end
  end

  // drives one operation for one cycle (called at a negedge)
  task automatic issue(logic [31:0] a, logic [31:0] b, logic m, string tag);
    inValid = 1'b1;
    inMode  = m;
    inA     = a;
    inB     = b;
    expVal[wrIdx % 64] = m ? refPlain(a, b) : refMod(a, b);
    expCyc[wrIdx % 64] = cyc;
    expTag[wrIdx % 64] = tag;
    wrIdx++;
    @(negedge clk);
  endtask

  task automatic drain();
    inValid = 1'b0;
    for (int i = 0; i < 6; i++) @(negedge clk);
    check("R3 all results returned", 32'(rdIdx), 32'(wrIdx));
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 outValid in reset", {31'd0, outValid}, 32'd0);
    check("R1 outResult in reset", outResult, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 outValid after reset", {31'd0, outValid}, 32'd0);
    check("R1 outResult after reset", outResult, 32'd0);
  endtask

  task automatic testModBasic();
    issue(32'd3, 32'd5, 1'b0, "R4 3*5");
    drain();
    issue(32'h0000_1234, 32'h0000_5678, 1'b0, "R4 1234*5678");
    drain();
    issue(32'hABCD_0002, 32'hFFFF_0003, 1'b0, "R4 upper bits ignored");
    drain();
    issue(32'h0000_FFFF, 32'h0000_FFFF, 1'b0, "R4 high half above low half");
    drain();
  endtask

  task automatic testWrap();
    issue(32'h0000_FFFF, 32'h0000_8001, 1'b0, "R5 residue 65536");
    drain();
    issue(32'h0000_0000, 32'h0000_0001, 1'b0, "R5 zero times one");
    drain();
  endtask

  task automatic testZero();
    issue(32'h0000_0000, 32'h0000_0002, 1'b0, "R6 A zero");
    drain();
    issue(32'h0000_0005, 32'h7777_0000, 1'b0, "R6 B zero");
    drain();
    issue(32'h1111_0000, 32'h2222_0000, 1'b0, "R7 both zero");
    drain();
  endtask

  task automatic testPlain();
    issue(32'h1234_5678, 32'h9ABC_DEF0, 1'b1, "R8 plain mixed");
    drain();
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R8 plain all ones");
    drain();
    issue(32'h0000_0000, 32'hDEAD_BEEF, 1'b1, "R8 plain zero");
    drain();
  endtask

  task automatic testStream();
    logic [31:0] lfsr;
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 24; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      issue(lfsr, {lfsr[15:0], lfsr[31:16]} ^ 32'h5A5A_0000, lfsr[3],
            lfsr[3] ? "R10 stream plain" : "R3 stream modular");
    end
    drain();
  endtask

  task automatic testIdle();
    logic [31:0] held;
    issue(32'd7, 32'd9, 1'b0, "R9 before idle");
    drain();
    held = outResult;
    for (int i = 0; i < 6; i++) begin
      inValid = 1'b0;
      inMode  = i[0];
      inA     = 32'hF0F0_0000 + 32'(i);
      inB     = 32'h0F0F_1111 * 32'(i + 1);
      @(negedge clk);
      check("R9 no valid while idle", {31'd0, outValid}, 32'd0);
      check("R9 result held", outResult, held);
    end
    issue(32'd2, 32'd3, 1'b1, "R9 gap op one");
    inValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    issue(32'd4, 32'd0, 1'b0, "R9 gap op two");
    drain();
  endtask

  initial begin
    testReset();
    testModBasic();
    testWrap();
    testZero();
    testPlain();
    testStream();
    testIdle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule